// File: doc/BRIEF.md
# Multi-Port Stream Merger with Selectable Priority and Hold Policy

This block merges several valid/ready/payload input streams into a single output stream. The policy that decides which input is served is fixed when the block is built. Three choices exist: the lowest-numbered requesting port wins; a rotating priority that shares access fairly; or a strict port order 0, 1, … that waits on the expected port. A separate hold policy, also fixed when the block is built, sets when the chosen port may change. It may change freely on every cycle, it may be held until the chosen transfer completes, or it may be held until a transfer flagged as the final beat of a burst completes.

The output carries the chosen port's payload and final-beat flag, together with the binary index of the chosen port. Only the chosen input sees the downstream ready. Output valid comes only from input valids and registered state, so it never depends on the downstream ready in the same cycle. The block adds no buffering and does not alter payloads.

Top module: `stream_arb`

## Requirements
- R1: A transfer happens only on a cycle where both out_valid and out_ready are high. In that cycle the selected input has in_valid and in_ready high, and out_data and out_last equal that input's payload slice (bits sel*DW upward) and its last bit.
- R2: Only the selected input's in_ready may be high, and it equals out_ready. Every other in_ready bit is low.
- R3: out_valid does not change when only out_ready changes within a cycle.
- R4: With lowest-first selection, out_sel is the binary index of the lowest-numbered input whose in_valid is high. out_valid is high whenever any in_valid is high and nothing is held.
- R5: With round-robin selection, the search after a completed grant to port g starts at port g+1 and wraps from N-1 to 0. After reset the search starts at port 0.
- R6: With sequential selection, ports are served in the order 0, 1, …, N-1, 0. While the expected port has no valid, out_valid stays low even if other ports are valid.
- R7: With the free hold policy, the selection may move to another port while the output is stalled.
- R8: With the per-transfer hold policy, a port that is presented but not accepted stays selected until its transfer completes, even if a higher-priority port becomes valid.
- R9: With the burst hold policy, the selected port stays selected from its first accepted beat until a beat with in_last high is accepted. While it is held and idle, out_valid is low even if other ports are valid.
- R10: Reset clears any hold and returns the rotating or sequential pointer to port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | PORTS | Per-input valid |
| in_ready | output | PORTS | Per-input ready |
| in_data | input | PORTS*DW | Concatenated input payloads, port i in bits i*DW upward |
| in_last | input | PORTS | Per-input final-beat flag |
| out_valid | output | 1 | Merged stream valid |
| out_ready | input | 1 | Merged stream ready |
| out_data | output | DW | Merged payload |
| out_last | output | 1 | Final-beat flag of the selected input |
| out_sel | output | $clog2(PORTS) | Binary index of the selected input |

## Verification
A walk over valid patterns with output stalled covers the lowest-first choice. Single, sparse, adjacent and full request masks distinguish a correct lowest-index search from an off-by-one or reversed scan. Directed runs then stall a port and raise a higher-priority request. This separates the free policy, which switches, from the per-transfer and burst policies, which hold. The rotating pointer is shown to wrap from the last port back to port 0 and to advance only on a completed grant. The sequential order is run through a full wrap, with a lagging port 0 to show that it waits instead of skipping.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;
  typedef enum logic [1:0] {
    ARB_LOWEST = 2'd0,
    ARB_ROUND  = 2'd1,
    ARB_SEQ    = 2'd2
  } arb_mode_e;

  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_XFER  = 2'd1,
    LK_BURST = 2'd2
  } lock_mode_e;
endpackage

// File: rtl/stream_arb_pick.sv
// Circular first-one search starting at base_i; base fixed at 0 yields lowest-first.
module stream_arb_pick #(
  parameter int PORTS = 4,
  parameter int IW    = 2
) (
  input  logic [PORTS-1:0] req_i,
  input  logic [IW-1:0]    base_i,
  output logic [IW-1:0]    pick_o
);
  function automatic int wrap_idx(input logic [IW-1:0] b, input int k);
    int s;
    s = int'(b) + k;
    if (s >= PORTS) s = s - PORTS;
    return s;
  endfunction

  always_comb begin
    pick_o = base_i;
    // descending so the smallest offset from base wins
    for (int k = PORTS - 1; k >= 0; k--) begin
      if (req_i[wrap_idx(base_i, k)]) pick_o = IW'(wrap_idx(base_i, k));
    end
  end
endmodule

// File: rtl/stream_arb_state.sv
module stream_arb_state
  import stream_arb_pkg::*;
#(
  parameter int         PORTS = 4,
  parameter int         IW    = 2,
  parameter lock_mode_e LOCK  = LK_XFER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cand_valid_i,
  input  logic          fire_i,
  input  logic          last_i,
  input  logic [IW-1:0] cur_sel_i,
  output logic [IW-1:0] ptr_o,
  output logic          held_o,
  output logic [IW-1:0] held_sel_o
);
  logic          release_w;
  logic [IW-1:0] ptr_d, ptr_q;
  logic          held_d, held_q;
  logic [IW-1:0] hsel_d, hsel_q;

  // a grant is finished on any fire, or only on the final beat in burst mode
  assign release_w = fire_i && ((LOCK != LK_BURST) || last_i);

  always_comb begin
    ptr_d = ptr_q;
    if (release_w) begin
      ptr_d = (cur_sel_i == IW'(PORTS - 1)) ? '0 : cur_sel_i + 1'b1;
    end
  end

  always_comb begin
    held_d = held_q;
    if (LOCK == LK_NONE)  held_d = 1'b0;
    else if (release_w)   held_d = 1'b0;
    else if (cand_valid_i) held_d = 1'b1;
    hsel_d = held_q ? hsel_q : cur_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      held_q <= 1'b0;
      hsel_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      held_q <= held_d;
      hsel_q <= hsel_d;
    end
  end

  assign ptr_o      = ptr_q;
  assign held_o     = held_q;
  assign held_sel_o = hsel_q;
endmodule

// File: rtl/stream_arb.sv
module stream_arb
  import stream_arb_pkg::*;
#(
  parameter int         PORTS = 4,
  parameter int         DW    = 8,
  parameter arb_mode_e  ARB   = ARB_ROUND,
  parameter lock_mode_e LOCK  = LK_XFER,
  localparam int        IW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PORTS-1:0]    in_valid,
  output logic [PORTS-1:0]    in_ready,
  input  logic [PORTS*DW-1:0] in_data,
  input  logic [PORTS-1:0]    in_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic                out_last,
  output logic [IW-1:0]       out_sel
);
  logic [IW-1:0] ptr_w, pick_w, base_w, hsel_w, sel_w;
  logic          held_w, fire_w;

  assign base_w = (ARB == ARB_LOWEST) ? '0 : ptr_w;

  stream_arb_pick #(.PORTS(PORTS), .IW(IW)) u_pick (
    .req_i  (in_valid),
    .base_i (base_w),
    .pick_o (pick_w)
  );

  always_comb begin
    if (held_w)             sel_w = hsel_w;
    else if (ARB == ARB_SEQ) sel_w = ptr_w;
    else                    sel_w = pick_w;
  end

  assign out_valid = in_valid[sel_w];
  assign out_data  = in_data[sel_w*DW +: DW];
  assign out_last  = in_last[sel_w];
  assign out_sel   = sel_w;
  assign fire_w    = out_valid && out_ready;

  for (genvar i = 0; i < PORTS; i++) begin : g_ready
    assign in_ready[i] = out_ready && (sel_w == IW'(i));
  end

  stream_arb_state #(.PORTS(PORTS), .IW(IW), .LOCK(LOCK)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .cand_valid_i (out_valid),
    .fire_i       (fire_w),
    .last_i       (out_last),
    .cur_sel_i    (sel_w),
    .ptr_o        (ptr_w),
    .held_o       (held_w),
    .held_sel_o   (hsel_w)
  );
endmodule

// File: rtl/stream_arb_chk.sv
module stream_arb_chk
  import stream_arb_pkg::*;
#(
  parameter int         PORTS = 4,
  parameter int         DW    = 8,
  parameter arb_mode_e  ARB   = ARB_ROUND,
  parameter lock_mode_e LOCK  = LK_XFER,
  localparam int        IW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PORTS-1:0]    in_valid,
  input logic [PORTS-1:0]    in_ready,
  input logic [PORTS*DW-1:0] in_data,
  input logic [PORTS-1:0]    in_last,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DW-1:0]       out_data,
  input logic                out_last,
  input logic [IW-1:0]       out_sel
);
  p_fire_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> in_valid[out_sel] && in_ready[out_sel]
      && (out_data == in_data[out_sel*DW +: DW]) && (out_last == in_last[out_sel]));

  p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready) && (!out_ready -> (in_ready == '0)));

  if (ARB == ARB_LOWEST && LOCK == LK_NONE) begin : g_low
    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|in_valid) |-> out_valid
        && ((in_valid & ((PORTS'(1) << out_sel) - PORTS'(1))) == '0));
  end

  if (ARB == ARB_SEQ) begin : g_seq
    p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && ((LOCK != LK_BURST) || out_last) |=>
        out_sel == (($past(out_sel) == IW'(PORTS - 1)) ? IW'(0)
                                                       : IW'($past(out_sel) + 1'b1)));
  end

  if (LOCK != LK_NONE) begin : g_hold
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_sel == $past(out_sel));
  end

  if (LOCK == LK_BURST) begin : g_burst
    p_burst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_last |=> $stable(out_sel));
  end
endmodule

bind stream_arb stream_arb_chk #(
  .PORTS (PORTS),
  .DW    (DW),
  .ARB   (ARB),
  .LOCK  (LOCK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_sel   (out_sel)
);

// File: tb/stream_arb_tb.sv
module stream_arb_tb;
  import stream_arb_pkg::*;

  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    vld;
  logic [N-1:0]    lst;
  logic            rdy;
  logic [N*DW-1:0] dat;

  logic [N-1:0] dt_rdy, fr_rdy, lo_rdy, sq_rdy;
  logic dt_v, fr_v, lo_v, sq_v, dt_l, fr_l, lo_l, sq_l;
  logic [DW-1:0] dt_d, fr_d, lo_d, sq_d;
  logic [IW-1:0] dt_s, fr_s, lo_s, sq_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign dat = {8'hA3, 8'hA2, 8'hA1, 8'hA0};

  stream_arb #(.PORTS(N), .DW(DW), .ARB(ARB_ROUND), .LOCK(LK_XFER)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(dt_rdy), .in_data(dat),
    .in_last(lst), .out_valid(dt_v), .out_ready(rdy), .out_data(dt_d),
    .out_last(dt_l), .out_sel(dt_s));

  stream_arb #(.PORTS(N), .DW(DW), .ARB(ARB_LOWEST), .LOCK(LK_BURST)) u_frag (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(fr_rdy), .in_data(dat),
    .in_last(lst), .out_valid(fr_v), .out_ready(rdy), .out_data(fr_d),
    .out_last(fr_l), .out_sel(fr_s));

  stream_arb #(.PORTS(N), .DW(DW), .ARB(ARB_LOWEST), .LOCK(LK_NONE)) u_low (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(lo_rdy), .in_data(dat),
    .in_last(lst), .out_valid(lo_v), .out_ready(rdy), .out_data(lo_d),
    .out_last(lo_l), .out_sel(lo_s));

  stream_arb #(.PORTS(N), .DW(DW), .ARB(ARB_SEQ), .LOCK(LK_NONE)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(sq_rdy), .in_data(dat),
    .in_last(lst), .out_valid(sq_v), .out_ready(rdy), .out_data(sq_d),
    .out_last(sq_l), .out_sel(sq_s));

  // {valid mask, expected out_valid, expected out_sel} for lowest-first, free policy
  localparam logic [6:0] VEC [8] = '{
    7'b0000_0_00, 7'b0001_1_00, 7'b0010_1_01, 7'b0110_1_01,
    7'b0100_1_10, 7'b1000_1_11, 7'b1100_1_10, 7'b1111_1_00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vld = '0;
    lst = '0;
    rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    // R10: reset state, nothing valid, pointers at port 0
    chk("R10 lo_valid", lo_v, 0);
    chk("R10 dt_valid", dt_v, 0);
    chk("R10 dt_sel", dt_s, 0);
    chk("R10 sq_sel", sq_s, 0);
    chk("R10 fr_valid", fr_v, 0);

    // R4 / R1: table walk, output stalled
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      vld = VEC[i][6:3];
      #1;
      chk("R4 out_valid", lo_v, VEC[i][2]);
      chk("R4 out_sel", lo_s, VEC[i][1:0]);
      if (VEC[i][2]) chk("R1 out_data", lo_d, 8'hA0 + VEC[i][1:0]);
    end

    // R2 / R3: ready steering, valid independent of ready
    @(negedge clk);
    vld = 4'b1010;
    rdy = 1'b0;
    #1;
    chk("R2 ready while stalled", lo_rdy, 4'b0000);
    chk("R3 valid with ready low", lo_v, 1);
    rdy = 1'b1;
    #1;
    chk("R2 ready steered", lo_rdy, 4'b0010);
    chk("R3 valid with ready high", lo_v, 1);

    // R7: free policy switches while stalled
    @(negedge clk);
    rdy = 1'b0;
    vld = 4'b0100;
    #1;
    chk("R7 stalled sel", lo_s, 2);
    @(negedge clk);
    vld = 4'b0101;
    #1;
    chk("R7 switch while stalled", lo_s, 0);

    // R8 / R5: round-robin with per-transfer hold
    do_reset();
    vld = 4'b0100;
    rdy = 1'b0;
    #1;
    chk("R5 first pick", dt_s, 2);
    @(negedge clk);
    vld = 4'b0101;
    #1;
    chk("R8 held under higher request", dt_s, 2);
    rdy = 1'b1;
    #1;
    chk("R8 presented", dt_v, 1);
    chk("R2 rr ready", dt_rdy, 4'b0100);
    @(negedge clk);
    #1;
    chk("R5 wrap after port 2", dt_s, 0);
    @(negedge clk);
    #1;
    chk("R5 rotate after port 0", dt_s, 2);

    // R9: burst hold, lowest-first
    do_reset();
    vld = 4'b0100;
    lst = 4'b0000;
    rdy = 1'b1;
    #1;
    chk("R9 first pick", fr_s, 2);
    @(negedge clk);
    vld = 4'b0101;
    #1;
    chk("R9 held mid burst", fr_s, 2);
    vld = 4'b0001;
    #1;
    chk("R9 idle hold valid", fr_v, 0);
    chk("R9 idle hold sel", fr_s, 2);
    @(negedge clk);
    vld = 4'b0101;
    lst = 4'b0100;
    #1;
    chk("R9 last beat sel", fr_s, 2);
    chk("R1 last passed", fr_l, 1);
    @(negedge clk);
    #1;
    chk("R9 released", fr_s, 0);

    // R6: sequential order waits on expected port
    do_reset();
    vld = 4'b1110;
    rdy = 1'b1;
    #1;
    chk("R6 wait valid", sq_v, 0);
    chk("R6 wait sel", sq_s, 0);
    @(negedge clk);
    #1;
    chk("R6 still waiting", sq_s, 0);
    vld = 4'b1111;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk("R6 order", sq_s, k % 4);
      chk("R1 seq data", sq_d, 8'hA0 + (k % 4));
      @(negedge clk);
    end

    finish_run();
  end
endmodule